// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block translates a (process ID, virtual page number, page offset) request into a physical address. It uses a frame-indexed translation table that has exactly one entry for each physical frame. The position of a matching entry is the frame number. Each entry stores the page number and process ID that currently own the frame, a valid flag, a modify flag and a link to the next entry in its collision chain.

The requested page number and process ID are combined by a small hash. The hash picks one of eight anchor slots, and each slot holds the first frame of a chain. The walker then visits one table entry per clock. It stops on the first valid entry whose page number and process ID both equal the request, and it returns that frame number with the original offset. It reports a page fault in three cases: the anchor slot is empty, the chain ends, or the chain is longer than the number of frames.

A write port loads anchor slots and table entries from outside. It is meant for use only while no lookup is in flight.

Top module: `ipt_lookup`

## Requirements
- R1: After reset, busy_o and done_o are 0 and every anchor slot is empty, so the first lookup faults.
- R2: The anchor slot used is (vpn xor pid) mod 8, the low three bits of the XOR of the two fields.
- R3: A request accepted while idle whose anchor slot is empty produces done_o and fault_o on the first edge after acceptance.
- R4: The walk visits one entry per cycle. A result decided at chain position k (head is 0) appears k+1 edges after the accepting edge. busy_o is 1 until done_o rises.
- R5: A hit requires the entry's valid flag, an equal page number and an equal process ID. An entry that fails any of these is passed over and the walk follows its link.
- R6: On a hit, paddr_o equals {frame index, request offset}.
- R7: A link whose most significant bit is 1 is null. When a non-matching entry has a null link, the walk ends with fault_o.
- R8: A chain that loops faults after exactly FRAME_N entries have been visited.
- R9: A hit on a request with req_write_i set sets that entry's modify flag. dirty_o on a hit reports the entry's modify flag after the access.
- R10: req_valid_i is ignored while busy_o is 1, and the lookup in flight completes with its own result.
- R11: done_o is a one-cycle pulse. hit_o and fault_o appear only with done_o and never together.
- R12: With wr_en_i set, wr_anchor_i=1 writes slot wr_idx_i[2:0] (head from wr_next_i[FRAME_W-1:0], valid from wr_valid_i). wr_anchor_i=0 writes entry wr_idx_i with the wr_* fields. The port is not used while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request, taken when idle |
| req_pid_i | input | PID_W | Requesting process ID |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_off_i | input | OFF_W | Page offset |
| req_write_i | input | 1 | Access is a write |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result pulse |
| hit_o | output | 1 | Translation found |
| fault_o | output | 1 | Page fault |
| paddr_o | output | FRAME_W+OFF_W | Physical address |
| dirty_o | output | 1 | Modify flag of hit entry after the access |
| wr_en_i | input | 1 | Table write strobe |
| wr_anchor_i | input | 1 | 1: anchor slot, 0: table entry |
| wr_idx_i | input | FRAME_W | Slot or frame index |
| wr_vpn_i | input | VPN_W | Entry page number |
| wr_pid_i | input | PID_W | Entry process ID |
| wr_valid_i | input | 1 | Entry or slot valid flag |
| wr_modify_i | input | 1 | Entry modify flag |
| wr_next_i | input | FRAME_W+1 | Entry link (MSB = null) or anchor head |

## Verification
Some properties are checked by assertions on every cycle. These are the single-cycle done pulse and the exclusive hit or fault flags. Others are the one-edge fault for an empty slot, the forced end of a walk at the last permitted step, the modify flag being set after a write hit, and the write port staying quiet while a walk is in flight. The remaining behaviour can only be shown by the bench's scenarios: the hash slot choice, the exact chain-position latency, skipping of invalid and wrong-process entries, null-link termination, loop detection after FRAME_N visits, and rejected requests while busy.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int HASH_W = 3
) (
  input  logic [HASH_W-1:0] vpn_lo_i,
  input  logic [HASH_W-1:0] pid_lo_i,
  output logic [HASH_W-1:0] slot_o
);
  // (vpn ^ pid) mod 2**HASH_W only depends on the low bits
  assign slot_o = vpn_lo_i ^ pid_lo_i;
endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
  parameter int FRAME_N  = 16,
  parameter int ANCHOR_N = 8,
  parameter int VPN_W    = 20,
  parameter int PID_W    = 8,
  localparam int FRAME_W = $clog2(FRAME_N),
  localparam int HASH_W  = $clog2(ANCHOR_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_anchor_i,
  input  logic [FRAME_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [PID_W-1:0]   wr_pid_i,
  input  logic               wr_valid_i,
  input  logic               wr_modify_i,
  input  logic [FRAME_W:0]   wr_next_i,
  input  logic               set_mod_i,
  input  logic [FRAME_W-1:0] set_idx_i,
  input  logic [HASH_W-1:0]  anc_slot_i,
  output logic               anc_v_o,
  output logic [FRAME_W-1:0] anc_head_o,
  input  logic [FRAME_W-1:0] ent_idx_i,
  output logic [VPN_W-1:0]   ent_vpn_o,
  output logic [PID_W-1:0]   ent_pid_o,
  output logic               ent_v_o,
  output logic               ent_m_o,
  output logic [FRAME_W:0]   ent_nxt_o
);
  logic               anc_v_q   [ANCHOR_N];
  logic [FRAME_W-1:0] anc_head_q[ANCHOR_N];
  logic [VPN_W-1:0]   ent_vpn_q [FRAME_N];
  logic [PID_W-1:0]   ent_pid_q [FRAME_N];
  logic               ent_v_q   [FRAME_N];
  logic               ent_m_q   [FRAME_N];
  logic [FRAME_W:0]   ent_nxt_q [FRAME_N];

  for (genvar a = 0; a < ANCHOR_N; a++) begin : g_anc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        anc_v_q[a]    <= 1'b0;
        anc_head_q[a] <= '0;
      end else if (wr_en_i && wr_anchor_i && wr_idx_i[HASH_W-1:0] == HASH_W'(a)) begin
        anc_v_q[a]    <= wr_valid_i;
        anc_head_q[a] <= wr_next_i[FRAME_W-1:0];
      end
    end
  end

  for (genvar f = 0; f < FRAME_N; f++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_vpn_q[f] <= '0;
        ent_pid_q[f] <= '0;
        ent_v_q[f]   <= 1'b0;
        ent_m_q[f]   <= 1'b0;
        ent_nxt_q[f] <= {1'b1, {FRAME_W{1'b0}}};
      end else if (wr_en_i && !wr_anchor_i && wr_idx_i == FRAME_W'(f)) begin
        ent_vpn_q[f] <= wr_vpn_i;
        ent_pid_q[f] <= wr_pid_i;
        ent_v_q[f]   <= wr_valid_i;
        ent_m_q[f]   <= wr_modify_i;
        ent_nxt_q[f] <= wr_next_i;
      end else if (set_mod_i && set_idx_i == FRAME_W'(f)) begin
        ent_m_q[f] <= 1'b1;
      end
    end
  end

  assign anc_v_o    = anc_v_q[anc_slot_i];
  assign anc_head_o = anc_head_q[anc_slot_i];
  assign ent_vpn_o  = ent_vpn_q[ent_idx_i];
  assign ent_pid_o  = ent_pid_q[ent_idx_i];
  assign ent_v_o    = ent_v_q[ent_idx_i];
  assign ent_m_o    = ent_m_q[ent_idx_i];
  assign ent_nxt_o  = ent_nxt_q[ent_idx_i];

  AST_MODIFY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mod_i |=> ent_m_q[$past(set_idx_i)]); // R9
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int FRAME_N = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int OFF_W   = 12,
  localparam int FRAME_W = $clog2(FRAME_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [PID_W-1:0]   req_pid_i,
  input  logic [VPN_W-1:0]   req_vpn_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic               req_write_i,
  input  logic               anc_v_i,
  input  logic [FRAME_W-1:0] anc_head_i,
  output logic [FRAME_W-1:0] ent_idx_o,
  input  logic [VPN_W-1:0]   ent_vpn_i,
  input  logic [PID_W-1:0]   ent_pid_i,
  input  logic               ent_v_i,
  input  logic               ent_m_i,
  input  logic [FRAME_W:0]   ent_nxt_i,
  output logic               set_mod_o,
  output logic [FRAME_W-1:0] set_idx_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               hit_o,
  output logic               fault_o,
  output logic [FRAME_W+OFF_W-1:0] paddr_o,
  output logic               dirty_o
);
  localparam logic [FRAME_W-1:0] LAST_STEP = FRAME_W'(FRAME_N - 1);

  walk_st_e           st_q;
  logic [FRAME_W-1:0] cur_q, steps_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [PID_W-1:0]   pid_q;
  logic [OFF_W-1:0]   off_q;
  logic               wr_q;
  logic               match;

  assign match     = ent_v_i && ent_vpn_i == vpn_q && ent_pid_i == pid_q;
  assign ent_idx_o = cur_q;
  assign set_mod_o = st_q == ST_WALK && match && wr_q;
  assign set_idx_o = cur_q;
  assign busy_o    = st_q == ST_WALK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      steps_q <= '0;
      vpn_q   <= '0;
      pid_q   <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      fault_o <= 1'b0;
      paddr_o <= '0;
      dirty_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      fault_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          vpn_q <= req_vpn_i;
          pid_q <= req_pid_i;
          off_q <= req_off_i;
          wr_q  <= req_write_i;
          if (anc_v_i) begin
            cur_q   <= anc_head_i;
            steps_q <= '0;
            st_q    <= ST_WALK;
          end else begin
            done_o  <= 1'b1;
            fault_o <= 1'b1;
          end
        end
        ST_WALK: begin
          if (match) begin
            done_o  <= 1'b1;
            hit_o   <= 1'b1;
            paddr_o <= {cur_q, off_q};
            dirty_o <= ent_m_i | wr_q;
            st_q    <= ST_IDLE;
          end else if (ent_nxt_i[FRAME_W] || steps_q == LAST_STEP) begin
            done_o  <= 1'b1;
            fault_o <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            cur_q   <= ent_nxt_i[FRAME_W-1:0];
            steps_q <= steps_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_EMPTY_SLOT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_valid_i && !anc_v_i) |=> (done_o && fault_o)); // R3
  AST_LOOP_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WALK && steps_q == LAST_STEP) |=> (st_q == ST_IDLE && done_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_HIT_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && fault_o)); // R11
  AST_RESULT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || fault_o) |-> done_o); // R11
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WALK && req_valid_i) |=> $stable(vpn_q) && $stable(pid_q)); // R10
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int FRAME_N  = 16,
  parameter int ANCHOR_N = 8,
  parameter int VPN_W    = 20,
  parameter int PID_W    = 8,
  parameter int OFF_W    = 12,
  localparam int FRAME_W = $clog2(FRAME_N),
  localparam int HASH_W  = $clog2(ANCHOR_N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [PID_W-1:0]         req_pid_i,
  input  logic [VPN_W-1:0]         req_vpn_i,
  input  logic [OFF_W-1:0]         req_off_i,
  input  logic                     req_write_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     hit_o,
  output logic                     fault_o,
  output logic [FRAME_W+OFF_W-1:0] paddr_o,
  output logic                     dirty_o,
  input  logic                     wr_en_i,
  input  logic                     wr_anchor_i,
  input  logic [FRAME_W-1:0]       wr_idx_i,
  input  logic [VPN_W-1:0]         wr_vpn_i,
  input  logic [PID_W-1:0]         wr_pid_i,
  input  logic                     wr_valid_i,
  input  logic                     wr_modify_i,
  input  logic [FRAME_W:0]         wr_next_i
);
  logic [HASH_W-1:0]  slot;
  logic               anc_v, ent_v, ent_m, set_mod;
  logic [FRAME_W-1:0] anc_head, ent_idx, set_idx;
  logic [VPN_W-1:0]   ent_vpn;
  logic [PID_W-1:0]   ent_pid;
  logic [FRAME_W:0]   ent_nxt;

  ipt_hash #(.HASH_W(HASH_W)) u_hash (
    .vpn_lo_i (req_vpn_i[HASH_W-1:0]),
    .pid_lo_i (req_pid_i[HASH_W-1:0]),
    .slot_o   (slot)
  );

  ipt_store #(
    .FRAME_N(FRAME_N), .ANCHOR_N(ANCHOR_N), .VPN_W(VPN_W), .PID_W(PID_W)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_anchor_i, .wr_idx_i, .wr_vpn_i, .wr_pid_i,
    .wr_valid_i, .wr_modify_i, .wr_next_i,
    .set_mod_i  (set_mod),
    .set_idx_i  (set_idx),
    .anc_slot_i (slot),
    .anc_v_o    (anc_v),
    .anc_head_o (anc_head),
    .ent_idx_i  (ent_idx),
    .ent_vpn_o  (ent_vpn),
    .ent_pid_o  (ent_pid),
    .ent_v_o    (ent_v),
    .ent_m_o    (ent_m),
    .ent_nxt_o  (ent_nxt)
  );

  ipt_walker #(
    .FRAME_N(FRAME_N), .VPN_W(VPN_W), .PID_W(PID_W), .OFF_W(OFF_W)
  ) u_walker (
    .clk_i, .rst_ni,
    .req_valid_i, .req_pid_i, .req_vpn_i, .req_off_i, .req_write_i,
    .anc_v_i    (anc_v),
    .anc_head_i (anc_head),
    .ent_idx_o  (ent_idx),
    .ent_vpn_i  (ent_vpn),
    .ent_pid_i  (ent_pid),
    .ent_v_i    (ent_v),
    .ent_m_i    (ent_m),
    .ent_nxt_i  (ent_nxt),
    .set_mod_o  (set_mod),
    .set_idx_o  (set_idx),
    .busy_o, .done_o, .hit_o, .fault_o, .paddr_o, .dirty_o
  );

  AST_NO_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !busy_o); // R12
endmodule

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb;
  localparam int FN = 16;
  localparam int FW = 4;
  localparam int OW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [7:0]  req_pid = 0;
  logic [19:0] req_vpn = 0;
  logic [11:0] req_off = 0;
  logic busy, done, hit, fault, dirty;
  logic [FW+OW-1:0] paddr;
  logic wr_en = 0, wr_anchor = 0, wr_valid = 0, wr_modify = 0;
  logic [FW-1:0] wr_idx = 0;
  logic [19:0] wr_vpn = 0;
  logic [7:0]  wr_pid = 0;
  logic [FW:0] wr_next = 0;

  int n_chk = 0, n_fail = 0;
  bit m_av[8]; int m_ah[8];
  int e_vpn[FN], e_pid[FN], e_nx[FN];
  bit e_v[FN], e_m[FN];

  always #10 clk = ~clk;

  ipt_lookup u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_pid_i(req_pid),
    .req_vpn_i(req_vpn), .req_off_i(req_off), .req_write_i(req_write),
    .busy_o(busy), .done_o(done), .hit_o(hit), .fault_o(fault), .paddr_o(paddr),
    .dirty_o(dirty), .wr_en_i(wr_en), .wr_anchor_i(wr_anchor), .wr_idx_i(wr_idx),
    .wr_vpn_i(wr_vpn), .wr_pid_i(wr_pid), .wr_valid_i(wr_valid),
    .wr_modify_i(wr_modify), .wr_next_i(wr_next)
  );

  task automatic chk(bit ok, string rq, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic put_anchor(int slot, bit v, int head);
    @(negedge clk);
    wr_en = 1; wr_anchor = 1; wr_idx = FW'(slot); wr_valid = v;
    wr_next = {1'b0, FW'(head)};
    @(negedge clk); wr_en = 0;
    m_av[slot] = v; m_ah[slot] = head;
  endtask

  task automatic put_entry(int f, int pid, int vpn, bit v, bit m, int nx);
    @(negedge clk);
    wr_en = 1; wr_anchor = 0; wr_idx = FW'(f); wr_pid = 8'(pid); wr_vpn = 20'(vpn);
    wr_valid = v; wr_modify = m;
    wr_next = (nx < 0) ? {1'b1, {FW{1'b0}}} : {1'b0, FW'(nx)};
    @(negedge clk); wr_en = 0;
    e_pid[f] = pid; e_vpn[f] = vpn; e_v[f] = v; e_m[f] = m; e_nx[f] = nx;
  endtask

  // behavioural reference: latency in edges after acceptance, hit and frame
  task automatic model(int pid, int vpn, output int lat, output bit h, output int fr);
    int slot = (vpn ^ pid) % 8; // R2
    int p;
    lat = 0; h = 0; fr = 0;
    if (!m_av[slot]) return;
    p = m_ah[slot];
    for (int s = 0; s < FN; s++) begin
      lat = s + 1;
      if (e_v[p] && e_vpn[p] == vpn && e_pid[p] == pid) begin h = 1; fr = p; return; end
      if (e_nx[p] < 0) return;
      p = e_nx[p];
    end
  endtask

  task automatic lookup(int pid, int vpn, int off, bit wr, string rq, bit poke);
    int lat, fr; bit h; bit exp_d;
    model(pid, vpn, lat, h, fr);
    @(negedge clk);
    req_valid = 1; req_pid = 8'(pid); req_vpn = 20'(vpn); req_off = 12'(off); req_write = wr;
    for (int n = 0; n <= lat; n++) begin
      @(negedge clk);
      if (n == 0) req_valid = 0;
      if (poke && n == 1) begin // R10: competing request while busy
        req_valid = 1; req_pid = 8'd0; req_vpn = 20'd1; req_off = 12'h5a5; req_write = 1;
      end
      if (poke && n == 2) begin req_valid = 0; req_write = 0; end
      exp_d = (n == lat);
      chk(done == exp_d, {rq, " R4 done timing"}, done, exp_d);
      chk(busy == !exp_d, {rq, " R4 busy"}, busy, !exp_d);
      if (exp_d) begin
        chk(hit == h && fault == !h, {rq, " R11 hit/fault"}, {hit, fault}, {h, !h});
        if (h) begin
          chk(paddr == {FW'(fr), 12'(off)}, {rq, " R6 paddr"}, paddr, {FW'(fr), 12'(off)});
          if (wr) e_m[fr] = 1;
          chk(dirty == e_m[fr], {rq, " R9 dirty"}, dirty, e_m[fr]);
        end
      end
    end
    req_valid = 0; req_write = 0;
    @(negedge clk);
    chk(!done && !hit && !fault, {rq, " R11 pulse ends"}, {done, hit, fault}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_av[i] = 0; m_ah[i] = 0; end
    for (int i = 0; i < FN; i++) begin
      e_vpn[i] = 0; e_pid[i] = 0; e_v[i] = 0; e_m[i] = 0; e_nx[i] = -1;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset outputs", {busy, done}, 0);
    rst_n = 1;
    lookup(5, 'h13, 'h123, 0, "R1/R3 empty after reset", 0);

    // slot 6 chain: frame 3 -> 9 -> 12 -> null (R12 loading)
    put_entry(3, 5, 'h13, 1, 0, 9);
    put_entry(9, 5, 'h1b, 1, 0, 12);
    put_entry(12, 2, 'h04, 1, 0, -1);
    put_anchor(6, 1, 3);
    lookup(5, 'h13, 'h0ab, 0, "R2/R6 head hit", 0);
    lookup(5, 'h1b, 'hfff, 0, "R4 second in chain", 1);
    lookup(2, 'h04, 'h001, 0, "R4 third in chain", 1);
    lookup(5, 'h23, 'h000, 0, "R7 null end fault", 1);
    lookup(13, 'h13, 'h010, 0, "R5 pid mismatch", 0);
    lookup(2, 'h04, 'h777, 1, "R9 write hit", 0);
    lookup(2, 'h04, 'h778, 0, "R9 modify kept", 0);
    lookup(5, 'h13, 'h779, 0, "R9 other clean", 0);

    put_entry(9, 5, 'h1b, 0, 0, 12);
    lookup(5, 'h1b, 'h100, 0, "R5 invalid skipped", 0);
    lookup(2, 'h04, 'h101, 0, "R5 walk passes invalid", 0);

    // slot 1: single entry; slot 2 empty
    put_entry(0, 0, 'h1, 1, 0, -1);
    put_anchor(1, 1, 0);
    lookup(0, 'h1, 'h321, 0, "R2 slot 1 hit", 0);
    lookup(0, 'h2, 'h321, 0, "R3 empty slot 2", 0);
    lookup(7, 'h6, 'h321, 0, "R2 xor to slot 1 miss", 0);

    // slot 3: loop 5 -> 7 -> 5
    put_entry(5, 9, 'h40, 1, 0, 7);
    put_entry(7, 9, 'h41, 1, 0, 5);
    put_anchor(3, 1, 5);
    lookup(0, 'h3, 'h0, 0, "R8 loop guard", 1);
    lookup(9, 'h4a, 'h0, 0, "R8 loop key hit", 0); // (0x4a^9)%8 = 3, frame? miss -> loop

    summary();
  end
endmodule